// File: doc/BRIEF.md
# USB Slave-FIFO Write Bridge

This block takes a fast, bursty byte stream, typically one large burst per processing frame, and feeds it to an external USB controller through that controller's asynchronous slave-FIFO write port. Bytes are held in a 2048-entry internal buffer. A drain sequencer then moves them one at a time onto the parallel data bus. For each byte it drives an active-low write strobe, and the device captures the bus on that strobe's falling edge. The device then commits full packets to its bulk-IN endpoint by itself.

The input side can accept one byte per clock. The output side never issues more than one write every eight clocks. The buffer therefore absorbs the mismatch between the two rates: a frame's burst lands quickly and then drains over many separate write cycles. When the device reports its endpoint full, the sequencer does not start a new write. When the buffer itself fills, the input side sees back-pressure. If a producer pushes anyway, a sticky error flag is raised and the refused byte is discarded.

The endpoint select lines toward the device carry a constant taken from a parameter. The device's output-enable and read strobes are held inactive, because this bridge only writes.

Top module: `usb_slfifo_writer`

## Requirements
- R1: While reset is asserted and right after it, `usb_slwr_n` is 1, `usb_fd` is 0, `in_ready` is 1 and `overflow` is 0.
- R2: Bytes appear on `usb_fd` at the falling edges of `usb_slwr_n` in exactly the order in which they were accepted (`in_valid` and `in_ready` both high at a rising clock edge), with none lost or repeated.
- R3: In each write cycle, `usb_fd` is stable for at least 2 clocks before `usb_slwr_n` falls. `usb_slwr_n` then stays low for exactly 3 clocks, and `usb_fd` keeps its value for at least 1 clock after the strobe rises.
- R4: Successive falling edges of `usb_slwr_n` are never fewer than 8 clocks apart. While the buffer holds data and `usb_full` is 0, they are exactly 8 clocks apart.
- R5: While `usb_full` is 1, no new write cycle starts and no byte leaves the buffer. Draining resumes with the next unsent byte once `usb_full` returns to 0.
- R6: The buffer stores 2048 bytes. `in_ready` stays 1 until 2048 undrained bytes are held, and then drops to 0.
- R7: A byte offered while `in_ready` is 0 is not stored. It never appears on `usb_fd`, and the bytes already stored are unaffected.
- R8: `overflow` rises in the clock after a cycle in which `in_valid` is 1 while `in_ready` is 0. It then stays 1 until reset.
- R9: `usb_fifoadr` always equals the parameter `EP_ADDR` (default 2'b10). `usb_sloe_n` and `usb_slrd_n` are always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte offered |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Buffer can accept a byte this cycle |
| overflow | output | 1 | Sticky flag: a byte was offered while the buffer was full |
| usb_full | input | 1 | Device endpoint FIFO full, active high |
| usb_fd | output | 8 | Parallel data bus to the device |
| usb_slwr_n | output | 1 | Active-low write strobe; the device latches on its falling edge |
| usb_slrd_n | output | 1 | Device read strobe, held inactive (1) |
| usb_sloe_n | output | 1 | Device output enable, held inactive (1) |
| usb_fifoadr | output | 2 | Fixed endpoint select |

## Verification
The bench first fills the buffer completely while the device reports full. It then offers one more byte and confirms that the byte is refused and the error flag sets. A design that dropped an old byte, stored the extra byte, or raised back-pressure one entry early would show a byte missing, an extra byte, or `in_ready` falling too early in the drained sequence. Toggling `usb_full` during drains targets a sequencer that ignores the flag or reads the buffer while stalled; either fault produces skipped or out-of-order bytes on the bus. A per-strobe monitor measures setup, low width, hold and the spacing between strobes. It catches data changing under the strobe and any pacing faster than one write per eight clocks.

// File: rtl/slfifo_pkg.sv
package slfifo_pkg;
    typedef enum logic [1:0] {
        DR_IDLE  = 2'd0,
        DR_SETUP = 2'd1,
        DR_LOW   = 2'd2,
        DR_HOLD  = 2'd3
    } drain_st_e;
endpackage

// File: rtl/slfifo_buffer.sv
module slfifo_buffer #(
    parameter int W     = 8,
    parameter int DEPTH = 2048
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [AW:0]   count;
    } buf_t;

    buf_t q, d;
    logic [W-1:0] mem [DEPTH];

    always_comb begin
        d = q;
        if (wr_en) d.wp = q.wp + 1'b1;
        if (rd_en) d.rp = q.rp + 1'b1;
        case ({wr_en, rd_en})
            2'b10:   d.count = q.count + 1'b1;
            2'b01:   d.count = q.count - 1'b1;
            default: d.count = q.count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[q.wp] <= wr_data;
    end

    assign rd_data = mem[q.rp];
    assign empty   = (q.count == '0);
    assign full    = (q.count == FULL_CNT);

    AST_NO_READ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (q.count != '0));                                   // R2
    AST_NO_WRITE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (q.count != FULL_CNT));                             // R7
endmodule

// File: rtl/slfifo_drain.sv
module slfifo_drain
    import slfifo_pkg::*;
#(
    parameter int W         = 8,
    parameter int PACE      = 8,
    parameter int SETUP_CYC = 2,
    parameter int LOW_CYC   = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         buf_empty,
    input  logic [W-1:0] buf_data,
    output logic         buf_rd,
    input  logic         dev_full,
    output logic [W-1:0] fd,
    output logic         slwr_n
);
    localparam int HOLD_CYC = PACE - 1 - SETUP_CYC - LOW_CYC;
    localparam int CW       = $clog2(PACE);

    typedef struct packed {
        drain_st_e     st;
        logic [CW-1:0] cnt;
        logic [W-1:0]  fd;
        logic          slwr_n;
    } drain_t;

    drain_t q, d;
    logic   rd_d;

    always_comb begin
        d    = q;
        rd_d = 1'b0;
        case (q.st)
            DR_IDLE: begin
                if (!buf_empty && !dev_full) begin
                    rd_d  = 1'b1;
                    d.fd  = buf_data;
                    d.st  = DR_SETUP;
                    d.cnt = CW'(SETUP_CYC - 1);
                end
            end
            DR_SETUP: begin
                if (q.cnt == '0) begin
                    d.st  = DR_LOW;
                    d.cnt = CW'(LOW_CYC - 1);
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            DR_LOW: begin
                if (q.cnt == '0) begin
                    d.st  = DR_HOLD;
                    d.cnt = CW'(HOLD_CYC - 1);
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: begin
                if (q.cnt == '0) d.st  = DR_IDLE;
                else             d.cnt = q.cnt - 1'b1;
            end
        endcase
        d.slwr_n = (d.st != DR_LOW);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: DR_IDLE, cnt: '0, fd: '0, slwr_n: 1'b1};
        else        q <= d;
    end

    assign buf_rd = rd_d;
    assign fd     = q.fd;
    assign slwr_n = q.slwr_n;

    AST_SETUP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.slwr_n) |-> ($stable(q.fd) && ($past(q.fd, 2) == q.fd))); // R3
    AST_LOW_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.slwr_n && !$fell(q.slwr_n)) |-> $stable(q.fd));             // R3
    AST_HOLD_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.slwr_n) |-> $stable(q.fd));                            // R3
    AST_FULL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == DR_IDLE && dev_full) |=> (q.st == DR_IDLE && $stable(q.fd))); // R5
endmodule

// File: rtl/usb_slfifo_writer.sv
module usb_slfifo_writer #(
    parameter int         W       = 8,
    parameter int         DEPTH   = 2048,
    parameter int         PACE    = 8,
    parameter logic [1:0] EP_ADDR = 2'b10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         in_ready,
    output logic         overflow,
    input  logic         usb_full,
    output logic [W-1:0] usb_fd,
    output logic         usb_slwr_n,
    output logic         usb_slrd_n,
    output logic         usb_sloe_n,
    output logic [1:0]   usb_fifoadr
);
    typedef struct packed {
        logic ovf;
    } top_t;

    top_t         q, d;
    logic         buf_full, buf_empty, buf_rd, wr_en;
    logic [W-1:0] buf_data;

    always_comb begin
        d = q;
        if (in_valid && buf_full) d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign wr_en = in_valid && !buf_full;

    slfifo_buffer #(.W(W), .DEPTH(DEPTH)) i_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (in_data),
        .rd_en   (buf_rd),
        .rd_data (buf_data),
        .empty   (buf_empty),
        .full    (buf_full)
    );

    slfifo_drain #(.W(W), .PACE(PACE)) i_drain (
        .clk       (clk),
        .rst_n     (rst_n),
        .buf_empty (buf_empty),
        .buf_data  (buf_data),
        .buf_rd    (buf_rd),
        .dev_full  (usb_full),
        .fd        (usb_fd),
        .slwr_n    (usb_slwr_n)
    );

    assign in_ready    = !buf_full;
    assign overflow    = q.ovf;
    assign usb_slrd_n  = 1'b1;
    assign usb_sloe_n  = 1'b1;
    assign usb_fifoadr = EP_ADDR;

    AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready) |=> overflow);                          // R8
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);                                         // R8
endmodule

// File: tb/test_usb_slfifo_writer.sv
module test_usb_slfifo_writer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       usb_full = 1'b0;
    logic       in_ready, overflow, usb_slwr_n, usb_slrd_n, usb_sloe_n;
    logic [7:0] usb_fd;
    logic [1:0] usb_fifoadr;

    always #2.5 clk = ~clk;

    usb_slfifo_writer i_usb_slfifo_writer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .overflow(overflow), .usb_full(usb_full),
        .usb_fd(usb_fd), .usb_slwr_n(usb_slwr_n), .usb_slrd_n(usb_slrd_n),
        .usb_sloe_n(usb_sloe_n), .usb_fifoadr(usb_fifoadr)
    );

    int checks = 0;
    int fails  = 0;
    logic [7:0] exp_mem [4096];
    int exp_wr = 0;
    int exp_rd = 0;
    int cyc = 0;
    int falls = 0;
    int last_fall = -100;
    int last_gap = 0;
    int stable_cnt = 0;
    int low_cnt = 0;
    logic [7:0] prev_fd = 8'h00;
    logic [7:0] fall_fd = 8'h00;
    logic prev_slwr = 1'b1;

    // start, count, step, stall-toggle
    localparam logic [31:0] VEC [6] = '{
        {8'h00, 8'd1,   8'd1,  8'd0},
        {8'hA5, 8'd16,  8'd3,  8'd0},
        {8'hFF, 8'd40,  8'd7,  8'd1},
        {8'h10, 8'd100, 8'd1,  8'd0},
        {8'h55, 8'd64,  8'd85, 8'd1},
        {8'h80, 8'd200, 8'd13, 8'd0}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // strobe monitor, sampled at the falling clock edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            chk(usb_fifoadr == 2'b10 && usb_sloe_n && usb_slrd_n, "R9 fixed lines",
                {usb_fifoadr, usb_sloe_n, usb_slrd_n}, 4'b1011);
            if (prev_slwr && !usb_slwr_n) begin
                chk(stable_cnt + 1 >= 2, "R3 setup", stable_cnt + 1, 2);
                chk(cyc - last_fall >= 8, "R4 min spacing", cyc - last_fall, 8);
                last_gap  = cyc - last_fall;
                last_fall = cyc;
                chk(usb_fd == exp_mem[exp_rd % 4096], "R2 order",
                    usb_fd, exp_mem[exp_rd % 4096]);
                exp_rd++;
                falls++;
                fall_fd = usb_fd;
                low_cnt = 1;
            end else if (!usb_slwr_n) begin
                low_cnt++;
                chk(usb_fd == fall_fd, "R3 stable while low", usb_fd, fall_fd);
            end else if (!prev_slwr && usb_slwr_n) begin
                chk(low_cnt == 3, "R3 low width", low_cnt, 3);
                chk(usb_fd == fall_fd, "R3 hold", usb_fd, fall_fd);
            end
            if (usb_fd != prev_fd) stable_cnt = 0;
            else                   stable_cnt++;
        end
        prev_fd   = usb_fd;
        prev_slwr = usb_slwr_n;
    end

    task automatic push(input logic [7:0] b);
        logic ok;
        in_valid = 1'b1;
        in_data  = b;
        do begin
            ok = in_ready;
            @(negedge clk);
        end while (!ok);
        exp_mem[exp_wr % 4096] = b;
        exp_wr++;
        in_valid = 1'b0;
    endtask

    task automatic wait_drain(input bit stall);
        int n = 0;
        while (exp_rd != exp_wr) begin
            usb_full = stall && ((n % 11) < 4);
            n++;
            @(negedge clk);
        end
        usb_full = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(usb_slwr_n == 1'b1, "R1 slwr_n in reset", usb_slwr_n, 1);
        chk(usb_fd == 8'h00, "R1 fd in reset", usb_fd, 0);
        chk(in_ready == 1'b1 && overflow == 1'b0, "R1 flags in reset",
            {in_ready, overflow}, 2'b10);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(usb_slwr_n == 1'b1 && overflow == 1'b0, "R1 idle after reset",
            {usb_slwr_n, overflow}, 2'b10);

        // vector table: burst in, drain out (R2, R3, R4, R5)
        for (int v = 0; v < 6; v++) begin
            logic [7:0] st, cnt, stp, stl;
            int f0;
            {st, cnt, stp, stl} = VEC[v];
            f0 = falls;
            for (int i = 0; i < int'(cnt); i++) push(8'(st + i * stp));
            wait_drain(stl[0]);
            chk(falls - f0 == int'(cnt), "R2 all bytes written", falls - f0, cnt);
            if (stl == 0 && cnt > 1)
                chk(last_gap == 8, "R4 streaming spacing", last_gap, 8);
        end

        // R5: device full holds everything
        begin
            int f0;
            usb_full = 1'b1;
            @(negedge clk);
            f0 = falls;
            for (int i = 0; i < 5; i++) push(8'hC0 + 8'(i));
            repeat (40) @(negedge clk);
            chk(falls == f0, "R5 no strobe while full", falls - f0, 0);
            chk(usb_slwr_n == 1'b1, "R5 strobe idle while full", usb_slwr_n, 1);
            usb_full = 1'b0;
            wait_drain(1'b0);
            chk(falls - f0 == 5, "R5 resumed drain", falls - f0, 5);
        end

        // R6/R7/R8: fill to capacity, then offer one more
        begin
            int f0;
            usb_full = 1'b1;
            @(negedge clk);
            f0 = falls;
            for (int i = 0; i < 2047; i++) push(8'(i * 7 + 3));
            chk(in_ready == 1'b1, "R6 ready at 2047", in_ready, 1);
            push(8'(2047 * 7 + 3));
            chk(in_ready == 1'b0, "R6 full at 2048", in_ready, 0);
            chk(overflow == 1'b0, "R8 no overflow yet", overflow, 0);
            in_valid = 1'b1;
            in_data  = 8'hEE;
            @(negedge clk);
            in_valid = 1'b0;
            @(negedge clk);
            chk(overflow == 1'b1, "R8 overflow set", overflow, 1);
            usb_full = 1'b0;
            wait_drain(1'b0);
            chk(falls - f0 == 2048, "R7 refused byte not stored", falls - f0, 2048);
            chk(overflow == 1'b1, "R8 overflow sticky", overflow, 1);
            chk(in_ready == 1'b1, "R6 ready after drain", in_ready, 1);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", exp_rd, exp_wr);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule